// File: doc/BRIEF.md
# Reservation Station with Tag Wakeup

This block buffers arithmetic instructions between the issue stage and a single ALU of an out-of-order core. An issued instruction is placed in any free slot of a 32-slot pool. One cycle later the register file answers with either a value or a producer tag for each source operand. The scheduler can also supply a bypass value for a producer that has just finished. Slots whose operands still wait on a tag watch a result broadcast bus and pick up the value when their tag appears.

Every cycle the lowest-numbered slot with both operands present is sent to the ALU and its slot is returned to the pool. A flush empties the whole station in one cycle. The issue stage is expected to watch the free-space count and hold back when it reaches zero.

Top module: `rs_station`

## Requirements
- R1: While `rst` or `flush` is high at a clock edge, every slot becomes empty, `freeCount` becomes 32, `aluInsId` becomes 0 (0 means no request), and any operand fill that was due in the next cycle is cancelled.
- R2: An instruction is accepted only when `issValid` is 1, `issType` is 0 and at least one slot is empty. An accepted instruction lowers `freeCount` by one. With `issType` equal to 1 the station is unchanged.
- R3: An accepted instruction takes the lowest-numbered empty slot. Among ready slots the lowest number is dispatched first, so allocation order is visible in dispatch order.
- R4: In the cycle after acceptance, each operand is filled in as follows. An unused operand (`issUseA`/`issUseB` = 0) becomes ready with value 0. Otherwise, if the dependency ready bit is 1, the register-file value is taken. Otherwise, if `bypValid` is 1 and `bypTag` equals the dependency tag, `bypVal` is taken. Otherwise the tag is kept and the operand waits.
- R5: A broadcast (`cdbValid`, `cdbTag`, `cdbVal`) whose tag equals an operand's dependency tag in that same fill cycle is captured, and the operand becomes ready.
- R6: A broadcast wakes every waiting operand, in any number of slots, whose stored tag equals `cdbTag`. The operand takes `cdbVal`.
- R7: A slot whose operands are both ready is dispatched at a clock edge no earlier than the edge that follows its fill cycle. After that edge `aluInsId`, `aluOpA`, `aluOpB`, `aluRobIdx` and `aluPc` carry the slot's contents, the slot is freed, and `freeCount` rises by one.
- R8: In a cycle with no dispatch, `aluInsId` returns to 0 after the clock edge.
- R9: `freeCount` always equals 32 minus the number of occupied slots and never exceeds 32. An issue presented while the count is 0 is dropped.
- R10: Dependency inputs presented in the cycle after a flush have no effect, and no request reaches the ALU from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous clear of all slots |
| issValid | input | 1 | Issue strobe |
| issType | input | 1 | 0 = arithmetic (accepted here), 1 = memory (ignored) |
| issInsId | input | 11 | Instruction id: opcode, funct3 and one extra bit; nonzero |
| issRobIdx | input | 5 | Reorder-buffer index of the instruction |
| issPc | input | 32 | Instruction address |
| issUseA | input | 1 | First source operand is used |
| issUseB | input | 1 | Second source operand is used |
| depReadyA | input | 1 | Register file: first operand has no pending producer |
| depTagA | input | 5 | Register file: producer tag of first operand |
| depValA | input | 32 | Register file: value of first operand |
| depReadyB | input | 1 | Register file: second operand has no pending producer |
| depTagB | input | 5 | Register file: producer tag of second operand |
| depValB | input | 32 | Register file: value of second operand |
| bypValid | input | 1 | Scheduler bypass valid |
| bypTag | input | 5 | Scheduler bypass producer tag |
| bypVal | input | 32 | Scheduler bypass value |
| cdbValid | input | 1 | Result broadcast valid |
| cdbTag | input | 5 | Result broadcast producer tag |
| cdbVal | input | 32 | Result broadcast value |
| aluInsId | output | 11 | Dispatched instruction id, 0 when idle |
| aluOpA | output | 32 | Dispatched first operand |
| aluOpB | output | 32 | Dispatched second operand |
| aluRobIdx | output | 5 | Dispatched reorder-buffer index |
| aluPc | output | 32 | Dispatched instruction address |
| freeCount | output | 6 | Number of empty slots |

## Verification
The bound properties check the free-space bookkeeping on every cycle. The count never exceeds 32, a flush returns it to 32 with the request id cleared, a type-1 issue never lowers it, and a dispatch without an acceptance raises it by exactly one. The properties cannot show which slot is picked, which operand source wins during the fill cycle, or whether a broadcast landing in that cycle is kept. The bench shows these through its scenarios: bypass hits, fill-cycle broadcasts, multi-slot wakeups, a full station and flush cancellation. Its behavioural model is compared against every output on every clock.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_ENTRIES = 32;
  localparam int XLEN       = 32;
  localparam int TAGW       = 5;
  localparam int IDW        = 11;
  localparam int IDXW       = $clog2(RS_ENTRIES);
  localparam int CNTW       = $clog2(RS_ENTRIES + 1);

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FILL  = 2'd1,
    SLOT_WAIT  = 2'd2
  } slotState_t;

  typedef struct packed {
    logic            clearAll;
    logic            acceptEn;
    logic [IDXW-1:0] allocSlot;
    logic            fillEn;
    logic [IDXW-1:0] fillSlot;
    logic            dispEn;
    logic [IDXW-1:0] dispSlot;
  } rsStrobe_t;

  typedef struct packed {
    logic            rdy;
    logic [XLEN-1:0] val;
    logic [TAGW-1:0] tag;
  } operand_t;

  function automatic operand_t resolveOperand(
    input logic            used,
    input logic            depRdy,
    input logic [TAGW-1:0] depTag,
    input logic [XLEN-1:0] depVal,
    input logic            bypValid,
    input logic [TAGW-1:0] bypTag,
    input logic [XLEN-1:0] bypVal,
    input logic            cdbValid,
    input logic [TAGW-1:0] cdbTag,
    input logic [XLEN-1:0] cdbVal);
    operand_t o;
    o.tag = depTag;
    if (!used) begin
      o.rdy = 1'b1; o.val = '0; o.tag = '0;
    end else if (depRdy) begin
      o.rdy = 1'b1; o.val = depVal;
    end else if (bypValid && bypTag == depTag) begin
      o.rdy = 1'b1; o.val = bypVal;
    end else if (cdbValid && cdbTag == depTag) begin
      o.rdy = 1'b1; o.val = cdbVal;
    end else begin
      o.rdy = 1'b0; o.val = '0;
    end
    return o;
  endfunction
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  issValid,
  input  logic                  issType,
  input  logic [RS_ENTRIES-1:0] slotEmpty,
  input  logic [RS_ENTRIES-1:0] slotReady,
  output rsStrobe_t             stb,
  output logic [CNTW-1:0]       freeCount
);
  logic            anyEmpty, anyReady;
  logic [IDXW-1:0] allocIdx, dispIdx;
  logic            fillPend;
  logic [IDXW-1:0] fillIdx;

  always_comb begin
    anyEmpty = 1'b0;
    allocIdx = '0;
    anyReady = 1'b0;
    dispIdx  = '0;
    for (int i = RS_ENTRIES - 1; i >= 0; i--) begin
      if (slotEmpty[i]) begin
        anyEmpty = 1'b1;
        allocIdx = IDXW'(i);
      end
      if (slotReady[i]) begin
        anyReady = 1'b1;
        dispIdx  = IDXW'(i);
      end
    end
  end

  always_comb begin
    stb.clearAll  = rst | flush;
    stb.acceptEn  = !stb.clearAll && issValid && !issType && anyEmpty;
    stb.allocSlot = allocIdx;
    stb.fillEn    = !stb.clearAll && fillPend;
    stb.fillSlot  = fillIdx;
    stb.dispEn    = !stb.clearAll && anyReady;
    stb.dispSlot  = dispIdx;
  end

  always_ff @(posedge clk) begin
    if (stb.clearAll) begin
      fillPend  <= 1'b0;
      fillIdx   <= '0;
      freeCount <= CNTW'(RS_ENTRIES);
    end else begin
      fillPend <= stb.acceptEn;
      fillIdx  <= allocIdx;
      case ({stb.dispEn, stb.acceptEn})
        2'b10:   freeCount <= freeCount + 1'b1;
        2'b01:   freeCount <= freeCount - 1'b1;
        default: freeCount <= freeCount;
      endcase
    end
  end
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
(
  input  logic                  clk,
  input  rsStrobe_t             stb,
  input  logic [IDW-1:0]        issInsId,
  input  logic [TAGW-1:0]       issRobIdx,
  input  logic [XLEN-1:0]       issPc,
  input  logic                  issUseA,
  input  logic                  issUseB,
  input  logic                  depReadyA,
  input  logic [TAGW-1:0]       depTagA,
  input  logic [XLEN-1:0]       depValA,
  input  logic                  depReadyB,
  input  logic [TAGW-1:0]       depTagB,
  input  logic [XLEN-1:0]       depValB,
  input  logic                  bypValid,
  input  logic [TAGW-1:0]       bypTag,
  input  logic [XLEN-1:0]       bypVal,
  input  logic                  cdbValid,
  input  logic [TAGW-1:0]       cdbTag,
  input  logic [XLEN-1:0]       cdbVal,
  output logic [RS_ENTRIES-1:0] slotEmpty,
  output logic [RS_ENTRIES-1:0] slotReady,
  output logic [IDW-1:0]        aluInsId,
  output logic [XLEN-1:0]       aluOpA,
  output logic [XLEN-1:0]       aluOpB,
  output logic [TAGW-1:0]       aluRobIdx,
  output logic [XLEN-1:0]       aluPc
);
  slotState_t      slotSt [RS_ENTRIES];
  logic [IDW-1:0]  slotId [RS_ENTRIES];
  logic [TAGW-1:0] slotRob[RS_ENTRIES];
  logic [XLEN-1:0] slotPc [RS_ENTRIES];
  logic            rdyA   [RS_ENTRIES];
  logic            rdyB   [RS_ENTRIES];
  logic [XLEN-1:0] valA   [RS_ENTRIES];
  logic [XLEN-1:0] valB   [RS_ENTRIES];
  logic [TAGW-1:0] tagA   [RS_ENTRIES];
  logic [TAGW-1:0] tagB   [RS_ENTRIES];
  logic            pendUseA, pendUseB;
  operand_t        fillA, fillB;

  for (genvar g = 0; g < RS_ENTRIES; g++) begin : g_flag
    assign slotEmpty[g] = (slotSt[g] == SLOT_EMPTY);
    assign slotReady[g] = (slotSt[g] == SLOT_WAIT) && rdyA[g] && rdyB[g];
  end

  always_comb begin
    fillA = resolveOperand(pendUseA, depReadyA, depTagA, depValA,
                           bypValid, bypTag, bypVal, cdbValid, cdbTag, cdbVal);
    fillB = resolveOperand(pendUseB, depReadyB, depTagB, depValB,
                           bypValid, bypTag, bypVal, cdbValid, cdbTag, cdbVal);
  end

  always_ff @(posedge clk) begin
    if (stb.acceptEn) begin
      pendUseA <= issUseA;
      pendUseB <= issUseB;
    end
    for (int i = 0; i < RS_ENTRIES; i++) begin
      if (stb.clearAll) begin
        slotSt[i] <= SLOT_EMPTY;
      end else if (stb.acceptEn && stb.allocSlot == IDXW'(i)) begin
        slotSt[i]  <= SLOT_FILL;
        slotId[i]  <= issInsId;
        slotRob[i] <= issRobIdx;
        slotPc[i]  <= issPc;
      end else if (stb.fillEn && stb.fillSlot == IDXW'(i)) begin
        slotSt[i] <= SLOT_WAIT;
        rdyA[i] <= fillA.rdy; valA[i] <= fillA.val; tagA[i] <= fillA.tag;
        rdyB[i] <= fillB.rdy; valB[i] <= fillB.val; tagB[i] <= fillB.tag;
      end else if (stb.dispEn && stb.dispSlot == IDXW'(i)) begin
        slotSt[i] <= SLOT_EMPTY;
      end else if (slotSt[i] == SLOT_WAIT && cdbValid) begin
        if (!rdyA[i] && tagA[i] == cdbTag) begin
          rdyA[i] <= 1'b1;
          valA[i] <= cdbVal;
        end
        if (!rdyB[i] && tagB[i] == cdbTag) begin
          rdyB[i] <= 1'b1;
          valB[i] <= cdbVal;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.clearAll) begin
      aluInsId  <= '0;
      aluOpA    <= '0;
      aluOpB    <= '0;
      aluRobIdx <= '0;
      aluPc     <= '0;
    end else if (stb.dispEn) begin
      aluInsId  <= slotId[stb.dispSlot];
      aluOpA    <= valA[stb.dispSlot];
      aluOpB    <= valB[stb.dispSlot];
      aluRobIdx <= slotRob[stb.dispSlot];
      aluPc     <= slotPc[stb.dispSlot];
    end else begin
      aluInsId  <= '0;
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            issValid,
  input  logic            issType,
  input  logic [IDW-1:0]  issInsId,
  input  logic [TAGW-1:0] issRobIdx,
  input  logic [XLEN-1:0] issPc,
  input  logic            issUseA,
  input  logic            issUseB,
  input  logic            depReadyA,
  input  logic [TAGW-1:0] depTagA,
  input  logic [XLEN-1:0] depValA,
  input  logic            depReadyB,
  input  logic [TAGW-1:0] depTagB,
  input  logic [XLEN-1:0] depValB,
  input  logic            bypValid,
  input  logic [TAGW-1:0] bypTag,
  input  logic [XLEN-1:0] bypVal,
  input  logic            cdbValid,
  input  logic [TAGW-1:0] cdbTag,
  input  logic [XLEN-1:0] cdbVal,
  output logic [IDW-1:0]  aluInsId,
  output logic [XLEN-1:0] aluOpA,
  output logic [XLEN-1:0] aluOpB,
  output logic [TAGW-1:0] aluRobIdx,
  output logic [XLEN-1:0] aluPc,
  output logic [CNTW-1:0] freeCount
);
  rsStrobe_t             stb;
  logic [RS_ENTRIES-1:0] slotEmpty, slotReady;

  rs_ctrl i_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .issValid(issValid), .issType(issType),
    .slotEmpty(slotEmpty), .slotReady(slotReady), .stb(stb), .freeCount(freeCount)
  );

  rs_datapath i_dp (
    .clk(clk), .stb(stb),
    .issInsId(issInsId), .issRobIdx(issRobIdx), .issPc(issPc),
    .issUseA(issUseA), .issUseB(issUseB),
    .depReadyA(depReadyA), .depTagA(depTagA), .depValA(depValA),
    .depReadyB(depReadyB), .depTagB(depTagB), .depValB(depValB),
    .bypValid(bypValid), .bypTag(bypTag), .bypVal(bypVal),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbVal(cdbVal),
    .slotEmpty(slotEmpty), .slotReady(slotReady),
    .aluInsId(aluInsId), .aluOpA(aluOpA), .aluOpB(aluOpB),
    .aluRobIdx(aluRobIdx), .aluPc(aluPc)
  );
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
  import rs_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            issValid,
  input logic            issType,
  input logic [IDW-1:0]  aluInsId,
  input logic [CNTW-1:0] freeCount
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    freeCount <= CNTW'(RS_ENTRIES));

  // R1
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (freeCount == CNTW'(RS_ENTRIES) && aluInsId == '0));

  // R2
  type_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (issValid && issType) |=> freeCount >= $past(freeCount));

  // R2
  accept_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (issValid && !issType && freeCount != '0 && !flush) |=> freeCount <= $past(freeCount));

  // R7
  dispatch_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && !(issValid && !issType)) |=>
      (aluInsId == '0 || freeCount == $past(freeCount) + 1'b1));
endmodule

bind rs_station rs_station_chk i_chk (
  .clk(clk), .rst(rst), .flush(flush), .issValid(issValid), .issType(issType),
  .aluInsId(aluInsId), .freeCount(freeCount)
);

// File: tb/test_rs_station.sv
`timescale 1ns/1ps
module test_rs_station;
  logic        clk = 0, rst = 1, flush = 0;
  logic        issValid = 0, issType = 0, issUseA = 0, issUseB = 0;
  logic [10:0] issInsId = 0;
  logic [4:0]  issRobIdx = 0;
  logic [31:0] issPc = 0;
  logic        depReadyA = 0, depReadyB = 0;
  logic [4:0]  depTagA = 0, depTagB = 0;
  logic [31:0] depValA = 0, depValB = 0;
  logic        bypValid = 0, cdbValid = 0;
  logic [4:0]  bypTag = 0, cdbTag = 0;
  logic [31:0] bypVal = 0, cdbVal = 0;
  logic [10:0] aluInsId;
  logic [31:0] aluOpA, aluOpB, aluPc;
  logic [4:0]  aluRobIdx;
  logic [5:0]  freeCount;

  rs_station i_rs_station (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  bit started = 0, done = 0;

  // behavioural reference
  int        mSt[32];
  bit [10:0] mId[32];
  bit [4:0]  mRob[32], mT1[32], mT2[32];
  bit [31:0] mPc[32], mV1[32], mV2[32];
  bit        mR1[32], mR2[32];
  int        mFree = 32, dSel, aSel, mPendSlot;
  bit        mPend = 0, mUse1, mUse2;
  bit [10:0] mAluId = 0;
  bit [31:0] mAluA, mAluB, mAluPc;
  bit [4:0]  mAluRob;

  task automatic res(input bit used, input bit rdy, input bit [4:0] t, input bit [31:0] v,
                     output bit ro, output bit [31:0] vo, output bit [4:0] to);
    to = t; vo = 0; ro = 0;
    if (!used) begin ro = 1; to = 0; end
    else if (rdy) begin ro = 1; vo = v; end
    else if (bypValid && bypTag == t) begin ro = 1; vo = bypVal; end
    else if (cdbValid && cdbTag == t) begin ro = 1; vo = cdbVal; end
  endtask

  always @(posedge clk) begin
    started <= 1;
    if (rst || flush) begin
      for (int i = 0; i < 32; i++) mSt[i] = 0;
      mFree = 32; mAluId = 0; mPend = 0;
    end else begin
      dSel = -1; aSel = -1;
      for (int i = 0; i < 32; i++) begin
        if (dSel < 0 && mSt[i] == 2 && mR1[i] && mR2[i]) dSel = i;
        if (aSel < 0 && mSt[i] == 0) aSel = i;
      end
      if (cdbValid)
        for (int i = 0; i < 32; i++)
          if (mSt[i] == 2) begin
            if (!mR1[i] && mT1[i] == cdbTag) begin mR1[i] = 1; mV1[i] = cdbVal; end
            if (!mR2[i] && mT2[i] == cdbTag) begin mR2[i] = 1; mV2[i] = cdbVal; end
          end
      if (dSel >= 0) begin
        mAluId = mId[dSel]; mAluA = mV1[dSel]; mAluB = mV2[dSel];
        mAluRob = mRob[dSel]; mAluPc = mPc[dSel];
        mSt[dSel] = 0; mFree++;
      end else mAluId = 0;
      if (mPend) begin
        res(mUse1, depReadyA, depTagA, depValA, mR1[mPendSlot], mV1[mPendSlot], mT1[mPendSlot]);
        res(mUse2, depReadyB, depTagB, depValB, mR2[mPendSlot], mV2[mPendSlot], mT2[mPendSlot]);
        mSt[mPendSlot] = 2;
      end
      mPend = 0;
      if (issValid && !issType && aSel >= 0) begin
        mSt[aSel] = 1; mId[aSel] = issInsId; mRob[aSel] = issRobIdx; mPc[aSel] = issPc;
        mUse1 = issUseA; mUse2 = issUseB; mPend = 1; mPendSlot = aSel; mFree--;
      end
    end
  end

  task automatic chk(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk(curReq, "freeCount", 32'(freeCount), 32'(mFree));
    chk(curReq, "aluInsId", 32'(aluInsId), 32'(mAluId));
    if (mAluId != 0) begin
      chk(curReq, "aluOpA", aluOpA, mAluA);
      chk(curReq, "aluOpB", aluOpB, mAluB);
      chk(curReq, "aluRobIdx", 32'(aluRobIdx), 32'(mAluRob));
      chk(curReq, "aluPc", aluPc, mAluPc);
    end
  end

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      finishRun();
    end
  end

  task automatic issue(input bit [10:0] id, input bit [4:0] rob, input bit [31:0] pc,
                       input bit ua, input bit ub);
    issValid = 1; issType = 0; issInsId = id; issRobIdx = rob; issPc = pc;
    issUseA = ua; issUseB = ub;
    @(negedge clk);
    issValid = 0;
  endtask

  task automatic dep(input bit ra, input bit [4:0] ta, input bit [31:0] va,
                     input bit rb, input bit [4:0] tb, input bit [31:0] vb);
    depReadyA = ra; depTagA = ta; depValA = va;
    depReadyB = rb; depTagB = tb; depValB = vb;
  endtask

  task automatic idle(input int n);
    issValid = 0; bypValid = 0; cdbValid = 0; flush = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    curReq = "R1";
    idle(2);
    chk("R1", "freeCount after reset", 32'(freeCount), 32);
    chk("R8", "idle request id", 32'(aluInsId), 0);

    curReq = "R2";
    issValid = 1; issType = 1; issInsId = 11'h7f; issUseA = 1; issUseB = 1;
    repeat (3) @(negedge clk);
    issValid = 0; issType = 0;
    idle(3);
    chk("R2", "type 1 ignored", 32'(freeCount), 32);

    curReq = "R4";
    issue(11'h013, 5'd3, 32'h100, 1, 0);
    dep(1, 5'd0, 32'd100, 0, 5'd0, 0);
    @(negedge clk);
    chk("R2", "count after accept", 32'(freeCount), 31);
    idle(1);
    chk("R7", "dispatched id", 32'(aluInsId), 32'h013);
    chk("R4", "unused operand zero", aluOpB, 0);
    idle(2);

    curReq = "R4";
    issue(11'h021, 5'd4, 32'h200, 1, 1);
    dep(0, 5'd12, 0, 1, 5'd0, 32'd7);
    bypValid = 1; bypTag = 5'd12; bypVal = 32'hB1;
    @(negedge clk);
    bypValid = 0;
    idle(1);
    chk("R4", "bypass operand", aluOpA, 32'hB1);
    idle(2);

    curReq = "R5";
    issue(11'h033, 5'd5, 32'h300, 1, 1);
    dep(0, 5'd9, 0, 1, 5'd0, 32'd2);
    cdbValid = 1; cdbTag = 5'd9; cdbVal = 32'hC9;
    @(negedge clk);
    cdbValid = 0;
    idle(1);
    chk("R5", "fill-cycle broadcast kept", aluOpA, 32'hC9);
    idle(2);

    curReq = "R3";
    issue(11'h101, 5'd10, 32'h400, 1, 0);
    dep(0, 5'd7, 0, 0, 0, 0);
    issue(11'h102, 5'd11, 32'h404, 1, 1);
    dep(0, 5'd7, 0, 0, 5'd8, 0);
    issue(11'h103, 5'd12, 32'h408, 0, 1);
    dep(0, 0, 0, 0, 5'd7, 0);
    @(negedge clk);
    curReq = "R6";
    cdbValid = 1; cdbTag = 5'd8; cdbVal = 32'h88;
    @(negedge clk);
    cdbTag = 5'd7; cdbVal = 32'h77;
    @(negedge clk);
    cdbValid = 0;
    chk("R6", "no early dispatch", 32'(aluInsId), 0);
    @(negedge clk);
    chk("R3", "lowest slot first", 32'(aluInsId), 32'h101);
    @(negedge clk);
    chk("R6", "second woken slot", 32'(aluInsId), 32'h102);
    @(negedge clk);
    chk("R7", "third woken slot", 32'(aluInsId), 32'h103);
    idle(2);

    curReq = "R9";
    for (int k = 0; k < 34; k++) begin
      dep(0, 5'd20, 0, 0, 5'd20, 0);
      issue(11'(k + 1), 5'(k), 32'(k * 4), 1, 1);
    end
    idle(2);
    chk("R9", "full station count", 32'(freeCount), 0);
    cdbValid = 1; cdbTag = 5'd20; cdbVal = 32'h2020;
    @(negedge clk);
    cdbValid = 0;
    idle(40);
    chk("R9", "drained count", 32'(freeCount), 32);

    curReq = "R10";
    issue(11'h055, 5'd1, 32'h500, 1, 1);
    flush = 1;
    dep(1, 0, 32'd1, 1, 0, 32'd2);
    @(negedge clk);
    flush = 0;
    idle(4);
    chk("R10", "fill after flush dropped", 32'(freeCount), 32);
    chk("R1", "flush request id", 32'(aluInsId), 0);

    curReq = "R7";
    for (int k = 0; k < 3000; k++) begin
      issValid  = ($urandom % 3) != 0;
      issType   = ($urandom % 4) == 0;
      issInsId  = 11'($urandom_range(1, 2047));
      issRobIdx = 5'($urandom);
      issPc     = $urandom;
      issUseA   = $urandom % 2;
      issUseB   = $urandom % 2;
      depReadyA = ($urandom % 2) == 0; depTagA = 5'($urandom % 4); depValA = $urandom;
      depReadyB = ($urandom % 2) == 0; depTagB = 5'($urandom % 4); depValB = $urandom;
      bypValid  = ($urandom % 4) == 0; bypTag = 5'($urandom % 4); bypVal = $urandom;
      cdbValid  = ($urandom % 2) == 0; cdbTag = 5'($urandom % 4); cdbVal = $urandom;
      flush     = ($urandom % 300) == 0;
      @(negedge clk);
    end
    issValid = 0;
    cdbValid = 1;
    for (int k = 0; k < 4; k++) begin
      cdbTag = 5'(k);
      @(negedge clk);
    end
    idle(40);
    curReq = "R8";
    chk("R8", "idle after drain", 32'(aluInsId), 0);
    finishRun();
  end
endmodule